// File: doc/BRIEF.md
# UART interrupt register unit

This unit is the interrupt slice of a serial port's register file. It tracks four interrupt causes: transmit level reached, receive level reached, transmit drained and receive overrun. Each cause has a sticky pending bit, an enable bit and an output line. Neighbouring datapath logic reports each cause with a one-cycle event pulse. The pending bit then stays set until software clears it.

Software uses three 32-bit word registers on a simple register bus. The pending register is cleared by writing ones. The enable register is a plain read/write register. The force register can only be written, and it sets pending bits so that software can exercise each interrupt line without the datapath. An output line is high while its pending bit and its enable bit are both set. Reads have no side effects and return data in the same cycle the read strobe is high.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the pending and enable registers are zero, every interrupt line is low, and reads at offsets 0x00, 0x04 and 0x08 return zero.
- R2: Bit positions are fixed in all three registers: bit 0 is transmit level reached, bit 1 receive level reached, bit 2 transmit drained, bit 3 receive overrun. An event pulse on `event_i[k]` sets pending bit k at the next clock edge.
- R3: A write to offset 0x00 clears each pending bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to offset 0x08 ORs write-data bits 3..0 into the pending register.
- R5: Each `irq_o[k]` equals pending bit k AND enable bit k, and it follows a change of either register in the same cycle that the register changes.
- R6: A write to offset 0x04 loads write-data bits 3..0 into the enable register. A read at 0x04 returns them in bits 3..0, with bits 31..4 zero.
- R7: A read at offset 0x08 returns zero whatever the pending register holds.
- R8: When an event pulse and a write-one-to-clear hit the same pending bit in one cycle, the bit ends up set.
- R9: A read at any other address, including one not aligned to a word, returns zero. A write there changes neither register.
- R10: A pending bit stays set over any number of cycles until a write to 0x00 clears it. Bits 31..4 of a pending read are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, one per cycle |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W (8) | Byte offset of the accessed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid while reg_re_i is high |
| event_i | input | NUM_SRC (4) | One-cycle set pulses from the datapath |
| irq_o | output | NUM_SRC (4) | Interrupt lines |

## Verification
The assertions assume that the strobes, address, write data and event pulses are settled and known at every rising edge after reset. They also assume that a cycle holds at most one bus access, so a write and a read never share an address phase. The bench changes every input only on the falling edge and asserts at most one strobe at a time. Event pulses are the one input it drives in the same cycle as a write, and it does so on purpose to exercise the set-over-clear case.

// File: rtl/uir_pkg.sv
package uir_pkg;
    localparam int REG_W      = 32;
    localparam int OFF_STATE  = 'h00;
    localparam int OFF_ENABLE = 'h04;
    localparam int OFF_TEST   = 'h08;

    // bit index of each cause, shared by all three registers (R2)
    typedef enum int {
        SRC_TX_LVL  = 0,
        SRC_RX_LVL  = 1,
        SRC_TX_IDLE = 2,
        SRC_RX_OVR  = 3
    } src_e;

    typedef struct packed {
        logic hit_state;
        logic hit_enable;
        logic hit_test;
    } sel_t;
endpackage

// File: rtl/uir_decode.sv
module uir_decode
    import uir_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_t              sel_o
);
    // full-width compare: misaligned or aliased offsets hit nothing (R9)
    always_comb begin
        sel_o            = '0;
        sel_o.hit_state  = (addr_i == ADDR_W'(OFF_STATE));
        sel_o.hit_enable = (addr_i == ADDR_W'(OFF_ENABLE));
        sel_o.hit_test   = (addr_i == ADDR_W'(OFF_TEST));
    end
endmodule

// File: rtl/uir_state_bank.sv
module uir_state_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] state_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } bank_t;

    bank_t              bank_d, bank_q;
    logic [NUM_SRC-1:0] bit_d;

    // set has priority over clear so that an event is never dropped (R8)
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        assign bit_d[k] = set_i[k] | (bank_q.bits[k] & ~clr_i[k]);
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.bits = bit_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign state_o = bank_q.bits;
endmodule

// File: rtl/uir_rdmux.sv
module uir_rdmux
    import uir_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               re_i,
    input  sel_t               sel_i,
    input  logic [NUM_SRC-1:0] state_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic [REG_W-1:0]   rdata_o
);
    localparam int PAD_W = REG_W - NUM_SRC;

    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            if (sel_i.hit_state) begin
                rdata_o = {{PAD_W{1'b0}}, state_i};
            end else if (sel_i.hit_enable) begin
                rdata_o = {{PAD_W{1'b0}}, enable_i};
            end
            // force register is write-only and reads as zero (R7)
        end
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uir_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               reg_we_i,
    input  logic               reg_re_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    input  logic [NUM_SRC-1:0] event_i,
    output logic [NUM_SRC-1:0] irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } en_reg_t;

    sel_t               sel;
    logic [NUM_SRC-1:0] wr_bits;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] set_mask;
    logic [NUM_SRC-1:0] state_q;
    logic [NUM_SRC-1:0] enable_q;
    en_reg_t            en_d, en_q;
    logic               unused_wdata;

    assign wr_bits      = reg_wdata_i[NUM_SRC-1:0];
    assign unused_wdata = ^reg_wdata_i[REG_W-1:NUM_SRC];

    uir_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (reg_addr_i),
        .sel_o  (sel)
    );

    always_comb begin
        clr_mask = (reg_we_i && sel.hit_state) ? wr_bits : '0;
        set_mask = event_i | ((reg_we_i && sel.hit_test) ? wr_bits : '0);
        en_d     = en_q;
        if (reg_we_i && sel.hit_enable) begin
            en_d.en = wr_bits;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign enable_q = en_q.en;

    uir_state_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set_mask),
        .clr_i   (clr_mask),
        .state_o (state_q)
    );

    uir_rdmux #(.NUM_SRC(NUM_SRC)) u_rdmux (
        .re_i     (reg_re_i),
        .sel_i    (sel),
        .state_i  (state_q),
        .enable_i (enable_q),
        .rdata_o  (reg_rdata_o)
    );

    assign irq_o = state_q & enable_q;
endmodule

// File: rtl/uir_chk.sv
module uir_chk
    import uir_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               we_i,
    input logic               re_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [REG_W-1:0]   wdata_i,
    input logic [REG_W-1:0]   rdata_i,
    input logic [NUM_SRC-1:0] event_i,
    input logic [NUM_SRC-1:0] irq_i,
    input logic [NUM_SRC-1:0] state_i,
    input logic [NUM_SRC-1:0] enable_i
);
    logic               at_state, at_enable, at_test, mapped;
    logic [NUM_SRC-1:0] w1c, force_bits, wlo;

    assign at_state   = (addr_i == ADDR_W'(OFF_STATE));
    assign at_enable  = (addr_i == ADDR_W'(OFF_ENABLE));
    assign at_test    = (addr_i == ADDR_W'(OFF_TEST));
    assign mapped     = at_state | at_enable | at_test;
    assign wlo        = wdata_i[NUM_SRC-1:0];
    assign w1c        = (we_i && at_state) ? wlo : '0;
    assign force_bits = (we_i && at_test) ? wlo : '0;

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i != '0) |=> ((state_i & $past(event_i)) == $past(event_i)));

    // R10
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(state_i) & ~$past(w1c) & ~state_i) == '0));

    // R3
    no_stray_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((state_i & ~$past(state_i) & ~$past(event_i) & ~$past(force_bits)) == '0));

    // R4
    force_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && at_test) |=> ((state_i & $past(wlo)) == $past(wlo)));

    // R6
    enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && at_enable) |=> (enable_i == $past(wlo)));

    // R7
    test_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && at_test) |-> (rdata_i == '0));

    // R9
    unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && !mapped) |-> (rdata_i == '0));

    // R9
    unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !mapped && event_i == '0) |=> ($stable(enable_i) && ((state_i & ~$past(state_i)) == '0)));

    // R5
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_i & ~state_i) == '0) && ((irq_i & ~enable_i) == '0));
endmodule

bind uart_irq_regs uir_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .re_i     (reg_re_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_i  (reg_rdata_o),
    .event_i  (event_i),
    .irq_i    (irq_o),
    .state_i  (state_q),
    .enable_i (enable_q)
);

// File: tb/sim_uart_irq_regs.sv
module sim_uart_irq_regs;
    localparam int N = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  ev = '0;
    logic [N-1:0]  irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_regs #(.NUM_SRC(N), .ADDR_W(AW)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_re_i    (re),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .event_i     (ev),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one cycle with optional write and event pulse, driven on falling edges
    task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [31:0] d, input logic [N-1:0] e);
        @(negedge clk);
        we = w; addr = a; wdata = d; ev = e;
        @(negedge clk);
        we = 1'b0; ev = '0; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, '0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        re = 1'b1; addr = a;
        #1;
        v = rdata;
        re = 1'b0; addr = '0;
    endtask

    task automatic load_state(input logic [N-1:0] s);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h08, {28'h0, s});
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h00, v); chk("R1 pending after reset", v, 32'h0);
        rd(8'h04, v); chk("R1 enable after reset", v, 32'h0);
        rd(8'h08, v); chk("R1 force after reset", v, 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2: each event bit lands on its own pending bit, and stays (R10)
        for (int k = 0; k < N; k++) begin
            wr(8'h00, 32'hF);
            cyc(1'b0, 8'h00, 32'h0, N'(1 << k));
            rd(8'h00, v); chk("R2 event sets its bit", v, 32'(1 << k));
            repeat (5) @(negedge clk);
            rd(8'h00, v); chk("R10 bit held", v, 32'(1 << k));
        end

        // R3 sweep of pending x clear mask
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                load_state(N'(s));
                wr(8'h00, 32'hFFFF_FFF0 | 32'(c));
                rd(8'h00, v); chk("R3 w1c", v, 32'(s & ~c & 4'hF));
            end
        end

        // R4 sweep of pending x force value
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 16; t++) begin
                load_state(N'(s));
                wr(8'h08, 32'hABCD_0000 | 32'(t));
                rd(8'h00, v); chk("R4 force or", v, 32'(s | t));
                rd(8'h08, v); chk("R7 force reads zero", v, 32'h0);
            end
        end

        // R5/R6 sweep of pending x enable
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                load_state(N'(s));
                wr(8'h04, 32'hFFFF_FFF0 | 32'(e));
                chk("R5 irq and", 32'(irq), 32'(s & e));
                rd(8'h04, v); chk("R6 enable readback", v, 32'(e));
            end
        end

        // R5: line drops in the cycle the clear lands
        wr(8'h04, 32'hF);
        load_state(4'hF);
        wr(8'h00, 32'h5);
        chk("R5 irq after clear", 32'(irq), 32'hA);

        // R8: event and clear on the same bit, and on other bits
        for (int k = 0; k < N; k++) begin
            load_state(4'h0);
            cyc(1'b1, 8'h00, 32'hF, N'(1 << k));
            rd(8'h00, v); chk("R8 set wins", v, 32'(1 << k));
            load_state(4'hF);
            cyc(1'b1, 8'h00, 32'hF, N'(1 << k));
            rd(8'h00, v); chk("R8 set wins other bits cleared", v, 32'(1 << k));
        end

        // R9: unmapped and misaligned accesses
        wr(8'h04, 32'h6);
        load_state(4'h9);
        for (int a = 0; a < 64; a++) begin
            if (a != 0 && a != 4 && a != 8) begin
                wr(AW'(a), 32'hFFFF_FFFF);
                rd(AW'(a), v); chk("R9 unmapped read", v, 32'h0);
            end
        end
        rd(8'h00, v); chk("R9 pending untouched", v, 32'h9);
        rd(8'h04, v); chk("R9 enable untouched", v, 32'h6);
        chk("R9 irq untouched", 32'(irq), 32'h0);
        wr(8'hF0, 32'hF);
        rd(8'h00, v); chk("R9 high offset no effect", v, 32'h9);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule